// File: doc/BRIEF.md
# SPI Serial EEPROM Slave Command Controller

This block is the digital front end of a serial EEPROM that answers as a slave on an SPI bus. A host selects the part with an active-low select, clocks instruction bytes into it most significant bit first, and receives data back on a serial output that is tri-stated whenever the part is not driving. The block decodes six instructions. Two set and clear a write-enable latch. Two read and write an 8-bit status word. The other two read the array sequentially and write between one byte and a full 128-byte page into it. The array itself is a parameterised register file addressed by a 16-bit address, and its depth can be made small for simulation.

The bus pins are oversampled by the system clock. Serial input is taken on rising bus-clock edges and the serial output changes on falling edges, so both mode 0 (clock idles low) and mode 3 (clock idles high) work. When the select line rises at the end of a valid write, the data is committed during a self-timed busy interval that lasts `WRITE_CYCLES` system clocks. During that interval only the status read is honoured. A pair of block-protect bits in the status word makes the top quarter, the top half or the whole array read-only. A status-protect bit, combined with an active-low write-protect pin, freezes the status word. An active-low hold input pauses a transfer without deselecting the part.

Top module: `spi_eeprom_slave`

## Requirements
- R1: After reset the status word reads 0x00, `sdoOe` is low, and every array byte reads as the erased value 0xFF.
- R2: Input bits are taken on rising `sclk` edges and output bits change on falling edges, most significant bit first. Transfers work with `sclk` idling low (mode 0) and idling high (mode 3).
- R3: Opcode 0x06 sets the write-enable latch (status bit 1) and opcode 0x04 clears it.
- R4: Opcode 0x02 followed by a 16-bit address and data bytes writes the array. With the latch clear, the command changes nothing: no busy interval starts and the array is unchanged.
- R5: Write data fills consecutive bytes and wraps to the start of the current 128-byte page instead of crossing into the next one.
- R6: An accepted write or status write starts when `csN` rises. Status bit 0 (busy) reads 1 for `WRITE_CYCLES` clocks, and then reads 0 with the latch cleared.
- R7: While busy, every instruction except status read (0x05) is rejected. A read leaves `sdoOe` low, and latch-set and status-write have no effect.
- R8: A write command that ends with a partial byte is discarded whole: no busy interval, array unchanged, latch unchanged.
- R9: Opcode 0x05 shifts out the status word, repeating it for each further byte. Opcode 0x01 followed by one byte writes only bit 7 (status protect) and bits 3:2 (block protect); the other bits read 0 apart from the busy and latch flags.
- R10: Block-protect value 01 makes the top quarter of the array read-only, 10 the top half, and 11 all of it. Writes aimed there are dropped and the latch stays set.
- R11: With status bit 7 set and `wpN` low, a status write is rejected. With `wpN` high, it is accepted.
- R12: Opcode 0x03 followed by a 16-bit address streams bytes from incrementing addresses across the whole array and rolls over from the top byte to byte 0. Address bits above the array depth are ignored.
- R13: While `holdN` is low with `sclk` low, `sdoOe` is low and `sclk` edges are ignored. The transfer resumes intact after `holdN` returns high.
- R14: `sdoOe` is high only while the part is selected, not held, and in a read-data or status-read phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus and time the busy interval |
| rstN | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | Active-low chip select |
| sclk | input | 1 | Serial bus clock |
| sdi | input | 1 | Serial data from the host |
| holdN | input | 1 | Active-low transfer pause |
| wpN | input | 1 | Active-low hardware protect for the status word |
| sdo | output | 1 | Serial data to the host |
| sdoOe | output | 1 | Output enable for `sdo`; low means high impedance |

## Verification
The main function is driven in both clock idle polarities with directed single-byte writes, page writes that run past the page end, reads that start at the top address, and constrained-random writes of one to six bytes at random addresses. The random writes are each read back against a bench model. The page-crossing pattern separates in-page wrapping from a plain linear increment. The top-address read separates whole-array rollover from page wrapping. Writes issued with the latch clear, ended on a partial byte, aimed at a protected quarter or sent during the busy interval must leave the model unchanged, which separates the acceptance rules from one another. A hold inserted mid-byte, with clock edges toggled during it, shows whether those edges leak into the shifters.

// File: rtl/spi_eeprom_pkg.sv
package spi_eeprom_pkg;

  localparam logic [7:0] OP_STAT_WR  = 8'h01;
  localparam logic [7:0] OP_ARR_WR   = 8'h02;
  localparam logic [7:0] OP_ARR_RD   = 8'h03;
  localparam logic [7:0] OP_LATCH_CLR = 8'h04;
  localparam logic [7:0] OP_STAT_RD  = 8'h05;
  localparam logic [7:0] OP_LATCH_SET = 8'h06;

  typedef enum logic [2:0] {
    PH_CMD,
    PH_ADDR,
    PH_RDDATA,
    PH_WRDATA,
    PH_STRD,
    PH_STWR,
    PH_SKIP
  } phase_e;

  // strobes from control to datapath, plus a snapshot of the status word
  typedef struct packed {
    logic       shiftIn;
    logic       sdiBit;
    logic       shiftOut;
    logic       addrShift;
    logic       loadRead;
    logic       loadStatus;
    logic       startPage;
    logic       wrByte;
    logic       commitEn;
    logic [7:0] statusByte;
  } ee_strobe_t;

endpackage

// File: rtl/spi_eeprom_ctrl.sv
module spi_eeprom_ctrl
  import spi_eeprom_pkg::*;
#(
  parameter int PAGE_BYTES   = 128,
  parameter int WRITE_CYCLES = 250000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       sclk,
  input  logic       sdi,
  input  logic       holdN,
  input  logic       wpN,
  input  logic [7:0] rxByte,
  input  logic       pageProt,
  output ee_strobe_t stb,
  output logic       sdoOe
);

  localparam int CW = (WRITE_CYCLES > 1) ? $clog2(WRITE_CYCLES) : 1;
  localparam logic [CW-1:0] LAST_CNT   = CW'(WRITE_CYCLES - 1);
  localparam logic [CW-1:0] PAGE_LIMIT = CW'(PAGE_BYTES);

  // two-stage synchronisers for the bus pins
  logic [1:0] csSy, sclkSy, sdiSy, holdSy, wpSy;
  logic       csS, sclkS, sdiS, holdS, wpS;
  logic       csD, sclkD;
  logic       holdActive;
  logic       edgeOk, riseEv, fallEv, csRise;

  phase_e     phase;
  logic [2:0] bitCnt;
  logic       byteDoneD;
  logic       addrSecond;
  logic       isWrite;
  logic       gotData;
  logic       gotStat;
  logic       statNewProt;
  logic [1:0] statNewBp;

  logic          wel;
  logic          busy;
  logic          commitWr;
  logic [CW-1:0] busyCnt;
  logic          srProt;
  logic [1:0]    bpBits;

  assign csS   = csSy[1];
  assign sclkS = sclkSy[1];
  assign sdiS  = sdiSy[1];
  assign holdS = holdSy[1];
  assign wpS   = wpSy[1];

  assign edgeOk = !csS && !holdActive;
  assign riseEv = edgeOk && sclkS && !sclkD;
  assign fallEv = edgeOk && !sclkS && sclkD;
  assign csRise = csS && !csD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csSy       <= 2'b11;
      sclkSy     <= 2'b00;
      sdiSy      <= 2'b00;
      holdSy     <= 2'b11;
      wpSy       <= 2'b11;
      csD        <= 1'b1;
      sclkD      <= 1'b0;
      holdActive <= 1'b0;
    end else begin
      csSy       <= {csSy[0], csN};
      sclkSy     <= {sclkSy[0], sclk};
      sdiSy      <= {sdiSy[0], sdi};
      holdSy     <= {holdSy[0], holdN};
      wpSy       <= {wpSy[0], wpN};
      csD        <= csS;
      sclkD      <= sclkS;
      if (csS)        holdActive <= 1'b0;
      else if (!sclkS) holdActive <= !holdS;
    end
  end

  // transfer sequencing
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase       <= PH_CMD;
      bitCnt      <= 3'd0;
      byteDoneD   <= 1'b0;
      addrSecond  <= 1'b0;
      isWrite     <= 1'b0;
      gotData     <= 1'b0;
      gotStat     <= 1'b0;
      statNewProt <= 1'b0;
      statNewBp   <= 2'b00;
    end else if (csS) begin
      phase      <= PH_CMD;
      bitCnt     <= 3'd0;
      byteDoneD  <= 1'b0;
      addrSecond <= 1'b0;
      gotData    <= 1'b0;
      gotStat    <= 1'b0;
    end else begin
      byteDoneD <= riseEv && (bitCnt == 3'd7);
      if (riseEv) bitCnt <= bitCnt + 3'd1;
      if (byteDoneD) begin
        unique case (phase)
          PH_CMD: begin
            if (busy && rxByte != OP_STAT_RD) phase <= PH_SKIP;
            else begin
              case (rxByte)
                OP_STAT_RD: phase <= PH_STRD;
                OP_STAT_WR: phase <= PH_STWR;
                OP_ARR_RD: begin phase <= PH_ADDR; isWrite <= 1'b0; end
                OP_ARR_WR: begin phase <= PH_ADDR; isWrite <= 1'b1; end
                default:   phase <= PH_SKIP;
              endcase
            end
          end
          PH_ADDR: begin
            if (addrSecond) phase <= isWrite ? PH_WRDATA : PH_RDDATA;
            addrSecond <= 1'b1;
          end
          PH_WRDATA: gotData <= 1'b1;
          PH_STWR: begin
            if (!gotStat) begin
              statNewProt <= rxByte[7];
              statNewBp   <= rxByte[3:2];
              gotStat     <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // latch, status bits and the self-timed busy interval
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wel      <= 1'b0;
      busy     <= 1'b0;
      commitWr <= 1'b0;
      busyCnt  <= '0;
      srProt   <= 1'b0;
      bpBits   <= 2'b00;
    end else begin
      if (!csS && byteDoneD && phase == PH_CMD && !busy) begin
        if (rxByte == OP_LATCH_SET) wel <= 1'b1;
        if (rxByte == OP_LATCH_CLR) wel <= 1'b0;
      end
      if (busy) begin
        if (busyCnt == LAST_CNT) begin
          busy     <= 1'b0;
          wel      <= 1'b0;
          commitWr <= 1'b0;
          busyCnt  <= '0;
        end else begin
          busyCnt <= busyCnt + 1'b1;
        end
      end else if (csRise) begin
        if (phase == PH_WRDATA && bitCnt == 3'd0 && gotData && wel && !pageProt) begin
          busy     <= 1'b1;
          commitWr <= 1'b1;
          busyCnt  <= '0;
        end else if (phase == PH_STWR && bitCnt == 3'd0 && gotStat && wel &&
                     !(srProt && !wpS)) begin
          busy    <= 1'b1;
          busyCnt <= '0;
          srProt  <= statNewProt;
          bpBits  <= statNewBp;
        end
      end
    end
  end

  always_comb begin
    stb            = '0;
    stb.shiftIn    = riseEv;
    stb.sdiBit     = sdiS;
    stb.shiftOut   = fallEv;
    stb.addrShift  = riseEv && (phase == PH_ADDR);
    stb.commitEn   = busy && commitWr && (busyCnt < PAGE_LIMIT);
    stb.statusByte = {srProt, 3'b000, bpBits, wel, busy};
    if (byteDoneD && !csS) begin
      case (phase)
        PH_CMD:    stb.loadStatus = (rxByte == OP_STAT_RD);
        PH_ADDR: begin
          stb.startPage = addrSecond && isWrite;
          stb.loadRead  = addrSecond && !isWrite;
        end
        PH_RDDATA: stb.loadRead   = 1'b1;
        PH_WRDATA: stb.wrByte     = 1'b1;
        PH_STRD:   stb.loadStatus = 1'b1;
        default: ;
      endcase
    end
  end

  assign sdoOe = edgeOk && (phase == PH_RDDATA || phase == PH_STRD);

endmodule

// File: rtl/spi_eeprom_datapath.sv
module spi_eeprom_datapath
  import spi_eeprom_pkg::*;
#(
  parameter int MEM_BYTES  = 2048,
  parameter int PAGE_BYTES = 128
) (
  input  logic       clk,
  input  logic       rstN,
  input  ee_strobe_t stb,
  output logic [7:0] rxByte,
  output logic       soBit,
  output logic       pageProt
);

  localparam int AW = $clog2(MEM_BYTES);
  localparam int PW = $clog2(PAGE_BYTES);
  localparam int BW = AW - PW;

  logic [7:0]    inShift;
  logic [7:0]    outShift;
  logic [AW-1:0] addrReg;
  logic [BW-1:0] pageBase;
  logic [PW-1:0] pageOff;
  logic [PW-1:0] commitPtr;
  logic [7:0]    pageBuf   [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] pageValid;
  logic [7:0]    memArr    [MEM_BYTES];

  assign rxByte = inShift;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inShift  <= 8'h00;
      outShift <= 8'h00;
      soBit    <= 1'b0;
      addrReg  <= '0;
    end else begin
      if (stb.shiftIn)   inShift <= {inShift[6:0], stb.sdiBit};
      if (stb.addrShift) addrReg <= {addrReg[AW-2:0], stb.sdiBit};
      if (stb.shiftOut) begin
        soBit    <= outShift[7];
        outShift <= {outShift[6:0], 1'b0};
      end else if (stb.loadRead) begin
        outShift <= memArr[addrReg];
        addrReg  <= addrReg + 1'b1;
      end else if (stb.loadStatus) begin
        outShift <= stb.statusByte;
      end
    end
  end

  // page staging buffer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pageBase  <= '0;
      pageOff   <= '0;
      commitPtr <= '0;
      pageValid <= '0;
      for (int i = 0; i < PAGE_BYTES; i++) pageBuf[i] <= 8'h00;
    end else begin
      if (stb.startPage) begin
        pageBase  <= addrReg[AW-1:PW];
        pageOff   <= addrReg[PW-1:0];
        commitPtr <= '0;
        pageValid <= '0;
      end else if (stb.wrByte) begin
        pageBuf[pageOff]   <= inShift;
        pageValid[pageOff] <= 1'b1;
        pageOff            <= pageOff + 1'b1;
      end
      if (stb.commitEn) commitPtr <= commitPtr + 1'b1;
    end
  end

  // array: one byte per clock is committed during the busy interval
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < MEM_BYTES; i++) memArr[i] <= 8'hFF;
    end else if (stb.commitEn && pageValid[commitPtr]) begin
      memArr[{pageBase, commitPtr}] <= pageBuf[commitPtr];
    end
  end

  always_comb begin
    case (stb.statusByte[3:2])
      2'b00:   pageProt = 1'b0;
      2'b01:   pageProt = &pageBase[BW-1:BW-2];
      2'b10:   pageProt = pageBase[BW-1];
      default: pageProt = 1'b1;
    endcase
  end

endmodule

// File: rtl/spi_eeprom_slave.sv
module spi_eeprom_slave
  import spi_eeprom_pkg::*;
#(
  parameter int MEM_BYTES    = 2048,
  parameter int PAGE_BYTES   = 128,
  parameter int WRITE_CYCLES = 250000
) (
  input  logic clk,
  input  logic rstN,
  input  logic csN,
  input  logic sclk,
  input  logic sdi,
  input  logic holdN,
  input  logic wpN,
  output logic sdo,
  output logic sdoOe
);

  ee_strobe_t stb;
  logic [7:0] rxByte;
  logic       pageProt;

  spi_eeprom_ctrl #(
    .PAGE_BYTES  (PAGE_BYTES),
    .WRITE_CYCLES(WRITE_CYCLES)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .csN     (csN),
    .sclk    (sclk),
    .sdi     (sdi),
    .holdN   (holdN),
    .wpN     (wpN),
    .rxByte  (rxByte),
    .pageProt(pageProt),
    .stb     (stb),
    .sdoOe   (sdoOe)
  );

  spi_eeprom_datapath #(
    .MEM_BYTES (MEM_BYTES),
    .PAGE_BYTES(PAGE_BYTES)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .rxByte  (rxByte),
    .soBit   (sdo),
    .pageProt(pageProt)
  );

endmodule

// File: rtl/spi_eeprom_slave_chk.sv
module spi_eeprom_slave_chk (
  input logic       clk,
  input logic       rstN,
  input logic       csN,
  input logic       sclk,
  input logic       holdN,
  input logic       sdoOe,
  input logic [7:0] statWord
);

  AST_OE_DESELECTED: assert property (@(posedge clk) disable iff (!rstN)
    (csN && $past(csN) && $past(csN, 2)) |-> !sdoOe);  // R14

  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!holdN && $past(!holdN) && $past(!holdN, 2) && $past(!holdN, 3) &&
     !sclk && $past(!sclk) && $past(!sclk, 2) && $past(!sclk, 3)) |-> !sdoOe);  // R13

  AST_BUSY_NEEDS_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statWord[0]) |-> $past(statWord[1]));  // R4

  AST_BUSY_AFTER_DESELECT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statWord[0]) |-> (csN && $past(csN) && $past(csN, 2)));  // R6

  AST_BUSY_END_CLEARS_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    $fell(statWord[0]) |-> !statWord[1]);  // R6

  AST_STATUS_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (statWord[0] && $past(statWord[0])) |-> $stable(statWord[7:2]));  // R7

endmodule

bind spi_eeprom_slave spi_eeprom_slave_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .csN     (csN),
  .sclk    (sclk),
  .holdN   (holdN),
  .sdoOe   (sdoOe),
  .statWord(stb.statusByte)
);

// File: tb/spi_eeprom_slave_tb.sv
module spi_eeprom_slave_tb;

  localparam int MEMB = 1024;
  localparam int PAGEB = 128;
  localparam int WCYC = 2000;
  localparam int HP = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1;
  logic sclk = 1'b0;
  logic sdi = 1'b0;
  logic holdN = 1'b1;
  logic wpN = 1'b1;
  wire  sdo;
  wire  sdoOe;

  int   checks = 0;
  int   errors = 0;
  bit   mode3 = 1'b0;

  logic [7:0] model [MEMB];
  logic [7:0] wbuf  [256];
  bit         mWel = 1'b0;
  logic [1:0] mBp = 2'b00;
  bit         mSrp = 1'b0;

  spi_eeprom_slave #(
    .MEM_BYTES   (MEMB),
    .PAGE_BYTES  (PAGEB),
    .WRITE_CYCLES(WCYC)
  ) u_dut (
    .clk  (clk),
    .rstN (rstN),
    .csN  (csN),
    .sclk (sclk),
    .sdi  (sdi),
    .holdN(holdN),
    .wpN  (wpN),
    .sdo  (sdo),
    .sdoOe(sdoOe)
  );

  always #5 clk = ~clk;

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit isProt(input int addr);
    int a = addr % MEMB;
    case (mBp)
      2'b00:   return 1'b0;
      2'b01:   return a >= (3 * MEMB) / 4;
      2'b10:   return a >= MEMB / 2;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [7:0] expStatus(input bit busy);
    return {mSrp, 3'b000, mBp, mWel, busy};
  endfunction

  task automatic csLow();
    sclk = mode3;
    waitClk(2);
    csN = 1'b0;
    waitClk(HP);
  endtask

  task automatic csHigh();
    if (!mode3) sclk = 1'b0;
    waitClk(HP);
    csN = 1'b1;
    waitClk(3 * HP);
  endtask

  // one byte, optional hold inserted before the rising edge of bit holdAt
  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx, input int holdAt, input int nb);
    rx = 8'h00;
    for (int i = 7; i >= 8 - nb; i--) begin
      sclk = 1'b0;
      sdi = tx[i];
      waitClk(HP);
      if (i == holdAt) begin
        holdN = 1'b0;
        waitClk(5);
        check("R13 oe during hold", sdoOe, 1'b0);
        for (int k = 0; k < 2; k++) begin
          sclk = 1'b1;
          waitClk(4);
          sclk = 1'b0;
          waitClk(4);
        end
        check("R13 oe during hold toggles", sdoOe, 1'b0);
        holdN = 1'b1;
        waitClk(5);
      end
      rx[i] = sdo;
      sclk = 1'b1;
      waitClk(HP);
    end
  endtask

  task automatic sendOp(input logic [7:0] op);
    logic [7:0] rx;
    csLow();
    xfer(op, rx, -1, 8);
    csHigh();
  endtask

  task automatic latchSet();
    sendOp(8'h06);
    mWel = 1'b1;
  endtask

  task automatic readStatus(output logic [7:0] s0, output logic [7:0] s1);
    logic [7:0] rx;
    csLow();
    xfer(8'h05, rx, -1, 8);
    xfer(8'h00, s0, -1, 8);
    xfer(8'h00, s1, -1, 8);
    csHigh();
  endtask

  task automatic checkStatus(input string tag, input logic [7:0] exp);
    logic [7:0] s0, s1;
    readStatus(s0, s1);
    check(tag, s0, exp);
  endtask

  task automatic readCheck(input logic [15:0] addr, input int n, input string tag, input int holdByte);
    logic [7:0] rx;
    csLow();
    xfer(8'h03, rx, -1, 8);
    check("R14 oe low in command phase", sdoOe, 1'b0);
    xfer(addr[15:8], rx, -1, 8);
    xfer(addr[7:0], rx, -1, 8);
    for (int k = 0; k < n; k++) begin
      xfer(8'h00, rx, (k == holdByte) ? 4 : -1, 8);
      check(tag, rx, model[(int'(addr) + k) % MEMB]);
    end
    csHigh();
    check("R14 oe low after deselect", sdoOe, 1'b0);
  endtask

  // writes n bytes of wbuf; extraBits > 0 appends a partial byte
  task automatic writeArr(input logic [15:0] addr, input int n, input int extraBits);
    logic [7:0] rx;
    int base, off;
    csLow();
    xfer(8'h02, rx, -1, 8);
    xfer(addr[15:8], rx, -1, 8);
    xfer(addr[7:0], rx, -1, 8);
    for (int k = 0; k < n; k++) xfer(wbuf[k], rx, -1, 8);
    if (extraBits > 0) xfer(8'hA5, rx, -1, extraBits);
    csHigh();
    if (mWel && n > 0 && extraBits == 0 && !isProt(int'(addr))) begin
      base = (int'(addr) % MEMB) / PAGEB * PAGEB;
      off = int'(addr) % PAGEB;
      for (int k = 0; k < n; k++) model[base + (off + k) % PAGEB] = wbuf[k];
      mWel = 1'b0;
    end
  endtask

  task automatic writeStatus(input logic [7:0] v, output bit accepted);
    logic [7:0] rx;
    csLow();
    xfer(8'h01, rx, -1, 8);
    xfer(v, rx, -1, 8);
    csHigh();
    accepted = mWel && !(mSrp && !wpN);
    if (accepted) begin
      mSrp = v[7];
      mBp = v[3:2];
      mWel = 1'b0;
    end
  endtask

  task automatic waitIdle();
    waitClk(WCYC + 50);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] s0, s1, rx;
    bit acc;
    void'($urandom(32'd4242));
    for (int i = 0; i < MEMB; i++) model[i] = 8'hFF;

    waitClk(10);
    rstN = 1'b1;
    waitClk(5);
    check("R1 oe after reset", sdoOe, 1'b0);
    checkStatus("R1 status after reset", 8'h00);
    readCheck(16'h0000, 2, "R1 erased array", -1);

    // write with latch clear
    wbuf[0] = 8'h5A;
    writeArr(16'h0010, 1, 0);
    checkStatus("R4 no busy without latch", 8'h00);
    readCheck(16'h0010, 1, "R4 array untouched", -1);

    // latch set / clear
    latchSet();
    checkStatus("R3 latch set", 8'h02);
    sendOp(8'h04);
    mWel = 1'b0;
    checkStatus("R3 latch cleared", 8'h00);

    // byte write, busy behaviour
    latchSet();
    wbuf[0] = 8'hA5;
    writeArr(16'h0020, 1, 0);
    checkStatus("R6 busy right after write", 8'h03);
    csLow();
    xfer(8'h03, rx, -1, 8);
    xfer(8'h00, rx, -1, 8);
    xfer(8'h20, rx, -1, 8);
    xfer(8'h00, rx, -1, 8);
    check("R7 read rejected while busy", sdoOe, 1'b0);
    csHigh();
    sendOp(8'h06);
    waitIdle();
    checkStatus("R7 latch-set ignored while busy, R6 latch cleared", 8'h00);
    readCheck(16'h0020, 1, "R2 mode0 byte readback", -1);

    // busy duration
    latchSet();
    wbuf[0] = 8'h11;
    writeArr(16'h0021, 1, 0);
    waitClk(WCYC - 400);
    checkStatus("R6 still busy near end", 8'h03);
    waitClk(300);
    checkStatus("R6 idle after interval", 8'h00);

    // mode 3
    mode3 = 1'b1;
    latchSet();
    wbuf[0] = 8'h81; wbuf[1] = 8'h7E; wbuf[2] = 8'hC4;
    writeArr(16'h0040, 3, 0);
    waitIdle();
    readCheck(16'h0040, 3, "R2 mode3 readback", -1);
    mode3 = 1'b0;

    // page wrap
    latchSet();
    wbuf[0] = 8'h01; wbuf[1] = 8'h02; wbuf[2] = 8'h03; wbuf[3] = 8'h04;
    writeArr(16'h017E, 4, 0);
    waitIdle();
    readCheck(16'h017C, 4, "R5 page end", -1);
    readCheck(16'h0100, 3, "R5 page wrap to start", -1);
    readCheck(16'h0180, 1, "R5 next page untouched", -1);

    // partial byte
    latchSet();
    wbuf[0] = 8'h99;
    writeArr(16'h0030, 1, 3);
    checkStatus("R8 partial byte discarded", 8'h02);
    readCheck(16'h0030, 1, "R8 array unchanged", -1);

    // status write of writable bits only, repeated status bytes
    writeStatus(8'h77, acc);
    waitIdle();
    readStatus(s0, s1);
    check("R9 status write bits", s0, 8'h04);
    check("R9 status repeats", s1, 8'h04);

    // block protect upper quarter
    latchSet();
    wbuf[0] = 8'h3C;
    writeArr(16'h0300, 1, 0);
    checkStatus("R10 protected write dropped", 8'h06);
    readCheck(16'h0300, 1, "R10 protected byte unchanged", -1);
    wbuf[0] = 8'hE7;
    writeArr(16'h0200, 1, 0);
    waitIdle();
    readCheck(16'h0200, 1, "R10 unprotected byte written", -1);

    // status protect with pin
    latchSet();
    writeStatus(8'h88, acc);
    waitIdle();
    checkStatus("R11 status protect set", 8'h88);
    wbuf[0] = 8'h42;
    latchSet();
    writeArr(16'h0204, 1, 0);
    checkStatus("R10 upper half protected", 8'h8A);
    wpN = 1'b0;
    writeStatus(8'h00, acc);
    checkStatus("R11 status write blocked by pin", 8'h8A);
    wpN = 1'b1;
    writeStatus(8'h00, acc);
    waitIdle();
    checkStatus("R11 status write allowed with pin high", 8'h00);

    // rollover
    latchSet();
    wbuf[0] = 8'hC3;
    writeArr(16'h03FF, 1, 0);
    waitIdle();
    latchSet();
    wbuf[0] = 8'h3C;
    writeArr(16'h0000, 1, 0);
    waitIdle();
    readCheck(16'hFFFF, 3, "R12 rollover read", -1);

    // hold mid-byte during a read
    readCheck(16'h0040, 3, "R13 read across hold", 1);

    // random writes
    for (int it = 0; it < 8; it++) begin
      logic [15:0] a;
      int n;
      mode3 = $urandom_range(0, 1);
      a = 16'($urandom);
      n = $urandom_range(1, 6);
      for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
      latchSet();
      writeArr(a, n, 0);
      waitIdle();
      readCheck(a, n, "R4 random write readback", -1);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule